// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits behind the write side of a byte-wide parallel NOR flash bus interface. It follows the unlock-and-command write sequences that a host issues, and turns each complete sequence into a single-cycle request to an operation engine. The decoded commands are: return to array read, byte program, whole-chip erase, sector erase, erase suspend, erase resume, and entry to the identification (autoselect) read mode. Each request carries the address and data byte of the write that completed the sequence.

Host writes arrive as synchronous one-cycle pulses that carry an address and a data byte. The decoder keeps the device mode: array read, identification read, or busy. While the engine is busy, the decoder ignores host writes, with two exceptions: an erase can be parked and woken again. In identification mode, a combinational read port returns the manufacturer code, the device code, or a sector's protection flag.

Top module: `nfd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read), `req_valid` is 0 and `id_rdata` is 00h.
- R2: In array-read or identification mode with no sequence in progress, a write of F0h to any address gives a request with `req_op`=1 (reset) and `mode` 0. The three-write form is also accepted: AAh to 555h, 55h to 2AAh, then F0h to 555h.
- R3: Writes of AAh to 555h, 55h to 2AAh and A0h to 555h, followed by a fourth write, give `req_op`=2 (program). The request carries the fourth write's address and data, and `mode` becomes 2 (busy). Only address bits 10:0 are compared against 555h and 2AAh.
- R4: The six-write sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h gives `req_op`=3 (chip erase) and `mode` 2.
- R5: The same five-write prefix followed by 30h to any address gives `req_op`=4 (sector erase) and `mode` 2. The request carries that address; bits 18:16 select one of eight sectors.
- R6: AAh@555h, 55h@2AAh, 90h@555h sets `mode` 1 (identification). In that mode, `id_rdata` depends on the read offset `rd_addr[15:0]`. Offset 0 returns 7Fh. Offset 1 returns DEV_ID (default A4h). Offset 2 returns 01h if the sector at `rd_addr[18:16]` is protected and 00h if it is not. Any other offset returns 00h. In every other mode, `id_rdata` is 00h.
- R7: A write that does not fit the expected next step of a sequence discards the partial sequence, returns `mode` to 0 and gives no request.
- R8: While `mode` is 2, writes give no request and leave the mode unchanged, except for the suspend case of R9. An `op_done` pulse returns `mode` to 0. Outside busy, `op_done` has no effect.
- R9: During a sector erase, a write of B0h gives `req_op`=5 (suspend) and `mode` 0. While suspended, only a write of 30h is accepted: it gives `req_op`=6 (resume) and `mode` 2. Other writes while suspended give nothing. During a program, B0h is ignored.
- R10: A program whose fourth-write address falls in a sector flagged in `prot_mask` gives no request and leaves `mode` at 0.
- R11: `req_valid` is high for exactly one cycle, in the cycle after the write that completed the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle host write pulse |
| wr_addr | input | 19 | Host write address |
| wr_data | input | 8 | Host write data byte |
| op_done | input | 1 | Engine finished the current operation |
| prot_mask | input | 8 | Per-sector protection flags, bit n = sector n |
| rd_addr | input | 19 | Read address for the identification port |
| req_valid | output | 1 | Single-cycle command request |
| req_op | output | 3 | Command code: 0 none, 1 reset, 2 program, 3 chip erase, 4 sector erase, 5 suspend, 6 resume |
| req_addr | output | 19 | Address of the completing write |
| req_data | output | 8 | Data of the completing write |
| mode | output | 2 | 0 array read, 1 identification, 2 busy |
| id_rdata | output | 8 | Identification read data |

## Verification
The bench walks a table of write sequences and then runs directed tests for the corner cases. One case aliases the command addresses with high address bits set; a decoder that compared the full address would never arm. Another breaks a sequence at its second step; a decoder that kept the partial state would later fire a command nobody issued. Other cases send B0h during a program and send writes while an erase is parked; a decoder that honoured them would raise spurious requests. A program to a protected sector must not leave the device busy, and an `op_done` pulse outside busy must not change the mode.

// File: rtl/nfd_pkg.sv
package nfd_pkg;
  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] ADR_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_B = 11'h2AA;

  localparam logic [7:0] K_UNLK_A = 8'hAA;
  localparam logic [7:0] K_UNLK_B = 8'h55;
  localparam logic [7:0] K_PROG   = 8'hA0;
  localparam logic [7:0] K_ERASE  = 8'h80;
  localparam logic [7:0] K_IDENT  = 8'h90;
  localparam logic [7:0] K_RESET  = 8'hF0;
  localparam logic [7:0] K_CHIP   = 8'h10;
  localparam logic [7:0] K_SECT   = 8'h30;
  localparam logic [7:0] K_SUSP   = 8'hB0;
  localparam logic [7:0] K_RESUME = 8'h30;
  localparam logic [7:0] MFR_CODE = 8'h7F;

  typedef enum logic [1:0] {MD_ARRAY = 2'd0, MD_IDENT = 2'd1, MD_BUSY = 2'd2} mode_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_RESET = 3'd1, OP_PROG = 3'd2, OP_CHIP = 3'd3,
    OP_SECT = 3'd4, OP_SUSP = 3'd5, OP_RESUME = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PRG, SQ_E3, SQ_E4, SQ_E5
  } seq_e;

  // Command addresses are matched on the low bits only.
  function automatic logic cmd_addr_is(input logic [CMD_AW-1:0] a,
                                       input logic [CMD_AW-1:0] pat);
    return a == pat;
  endfunction

  // Identification read table, indexed by offset.
  function automatic logic [7:0] ident_byte(input int unsigned off,
                                            input logic [7:0] dev,
                                            input logic prot);
    case (off)
      0:       return MFR_CODE;
      1:       return dev;
      2:       return {7'd0, prot};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/nfd_match.sv
module nfd_match
  import nfd_pkg::*;
#(
  parameter int SEC_BITS = 3
) (
  input  logic [CMD_AW-1:0]          cmd_lo,
  input  logic [SEC_BITS-1:0]        sec_sel,
  input  logic [(1<<SEC_BITS)-1:0]   prot_mask,
  output logic                       hit_a,
  output logic                       hit_b,
  output logic                       sec_prot
);
  assign hit_a    = cmd_addr_is(cmd_lo, ADR_A);
  assign hit_b    = cmd_addr_is(cmd_lo, ADR_B);
  assign sec_prot = prot_mask[sec_sel];
endmodule

// File: rtl/nfd_idrd.sv
module nfd_idrd
  import nfd_pkg::*;
#(
  parameter int AW       = 19,
  parameter int SEC_BITS = 3,
  parameter logic [7:0] DEV_ID = 8'hA4
) (
  input  mode_e                      md,
  input  logic [AW-1:0]              rd_addr,
  input  logic [(1<<SEC_BITS)-1:0]   prot_mask,
  output logic [7:0]                 rdata
);
  localparam int OFF_W = AW - SEC_BITS;

  logic [OFF_W-1:0]    off;
  logic [SEC_BITS-1:0] sec;

  assign off = rd_addr[OFF_W-1:0];
  assign sec = rd_addr[AW-1:OFF_W];

  always_comb begin
    if (md == MD_IDENT) rdata = ident_byte(int'(off), DEV_ID, prot_mask[sec]);
    else                rdata = 8'h00;
  end
endmodule

// File: rtl/nfd_seq.sv
module nfd_seq
  import nfd_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          op_done,
  input  logic          hit_a,
  input  logic          hit_b,
  input  logic          sec_prot,
  output logic          req_valid,
  output op_e           req_op,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_data,
  output mode_e         md,
  output logic          seq_idle,
  output logic          susp_o,
  output logic          ev_break,
  output logic          ev_drop
);
  seq_e  st, st_n;
  mode_e md_n;
  op_e   act, act_n, op_n;
  logic  sp, sp_n;

  always_comb begin
    st_n     = st;
    md_n     = md;
    sp_n     = sp;
    act_n    = act;
    op_n     = OP_NONE;
    ev_break = 1'b0;
    ev_drop  = 1'b0;
    if (md == MD_BUSY) begin
      if (wr_en && wr_data == K_SUSP && act == OP_SECT) begin
        op_n = OP_SUSP;
        md_n = MD_ARRAY;
        sp_n = 1'b1;
      end else if (op_done) begin
        md_n  = MD_ARRAY;
        act_n = OP_NONE;
      end
    end else if (sp) begin
      if (wr_en && wr_data == K_RESUME) begin
        op_n = OP_RESUME;
        md_n = MD_BUSY;
        sp_n = 1'b0;
      end
    end else if (wr_en) begin
      case (st)
        SQ_IDLE: begin
          if (wr_data == K_RESET) begin
            op_n = OP_RESET;
            md_n = MD_ARRAY;
          end else if (wr_data == K_UNLK_A && hit_a) st_n = SQ_U1;
          else ev_break = 1'b1;
        end
        SQ_U1: begin
          if (wr_data == K_UNLK_B && hit_b) st_n = SQ_U2;
          else ev_break = 1'b1;
        end
        SQ_U2: begin
          if (hit_a && wr_data == K_PROG) st_n = SQ_PRG;
          else if (hit_a && wr_data == K_ERASE) st_n = SQ_E3;
          else if (hit_a && wr_data == K_IDENT) begin
            st_n = SQ_IDLE;
            md_n = MD_IDENT;
          end else if (hit_a && wr_data == K_RESET) begin
            st_n = SQ_IDLE;
            op_n = OP_RESET;
            md_n = MD_ARRAY;
          end else ev_break = 1'b1;
        end
        SQ_PRG: begin
          st_n = SQ_IDLE;
          if (sec_prot) begin
            ev_drop = 1'b1;
            md_n    = MD_ARRAY;
          end else begin
            op_n  = OP_PROG;
            act_n = OP_PROG;
            md_n  = MD_BUSY;
          end
        end
        SQ_E3: begin
          if (wr_data == K_UNLK_A && hit_a) st_n = SQ_E4;
          else ev_break = 1'b1;
        end
        SQ_E4: begin
          if (wr_data == K_UNLK_B && hit_b) st_n = SQ_E5;
          else ev_break = 1'b1;
        end
        SQ_E5: begin
          st_n = SQ_IDLE;
          if (wr_data == K_CHIP && hit_a) begin
            op_n  = OP_CHIP;
            act_n = OP_CHIP;
            md_n  = MD_BUSY;
          end else if (wr_data == K_SECT) begin
            op_n  = OP_SECT;
            act_n = OP_SECT;
            md_n  = MD_BUSY;
          end else ev_break = 1'b1;
        end
        default: ev_break = 1'b1;
      endcase
      if (ev_break) begin
        st_n = SQ_IDLE;
        md_n = MD_ARRAY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      md        <= MD_ARRAY;
      sp        <= 1'b0;
      act       <= OP_NONE;
      req_valid <= 1'b0;
      req_op    <= OP_NONE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      st        <= st_n;
      md        <= md_n;
      sp        <= sp_n;
      act       <= act_n;
      req_valid <= (op_n != OP_NONE);
      req_op    <= op_n;
      if (op_n != OP_NONE) begin
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end

  assign seq_idle = (st == SQ_IDLE);
  assign susp_o   = sp;
endmodule

// File: rtl/nfd_decoder.sv
module nfd_decoder
  import nfd_pkg::*;
#(
  parameter int AW       = 19,
  parameter int SEC_BITS = 3,
  parameter logic [7:0] DEV_ID = 8'hA4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      op_done,
  input  logic [(1<<SEC_BITS)-1:0]  prot_mask,
  input  logic [AW-1:0]             rd_addr,
  output logic                      req_valid,
  output logic [2:0]                req_op,
  output logic [AW-1:0]             req_addr,
  output logic [7:0]                req_data,
  output logic [1:0]                mode,
  output logic [7:0]                id_rdata
);
  localparam int OFF_W = AW - SEC_BITS;

  logic  hit_a, hit_b, sec_prot;
  logic  seq_idle, susp_w, ev_break, ev_drop;
  op_e   op_w;
  mode_e md_w;

  nfd_match #(.SEC_BITS(SEC_BITS)) u_match (
    .cmd_lo   (wr_addr[CMD_AW-1:0]),
    .sec_sel  (wr_addr[AW-1:OFF_W]),
    .prot_mask(prot_mask),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .sec_prot (sec_prot)
  );

  nfd_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .op_done  (op_done),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .sec_prot (sec_prot),
    .req_valid(req_valid),
    .req_op   (op_w),
    .req_addr (req_addr),
    .req_data (req_data),
    .md       (md_w),
    .seq_idle (seq_idle),
    .susp_o   (susp_w),
    .ev_break (ev_break),
    .ev_drop  (ev_drop)
  );

  nfd_idrd #(.AW(AW), .SEC_BITS(SEC_BITS), .DEV_ID(DEV_ID)) u_idrd (
    .md       (md_w),
    .rd_addr  (rd_addr),
    .prot_mask(prot_mask),
    .rdata    (id_rdata)
  );

  assign req_op = op_w;
  assign mode   = md_w;
endmodule

// File: rtl/nfd_decoder_chk.sv
module nfd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       op_done,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic [1:0] mode,
  input logic       seq_idle,
  input logic       susp_w,
  input logic       ev_break,
  input logic       ev_drop
);
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  assert_f0_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && !susp_w && seq_idle && wr_en && wr_data == 8'hF0)
    |=> (req_valid && req_op == 3'd1 && mode == 2'd0));

  assert_prog_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2) |-> mode == 2'd2);

  assert_break_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break |=> (!req_valid && mode == 2'd0 && seq_idle));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && wr_en && wr_data != 8'hB0) |=> !req_valid);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && op_done) |=> mode == 2'd0);

  assert_susp_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_w && wr_en && wr_data != 8'h30) |=> (!req_valid && mode == 2'd0));

  assert_prot_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (!req_valid && mode == 2'd0));

  assert_req_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($past(wr_en) && req_op != 3'd0));
endmodule

bind nfd_decoder nfd_decoder_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .op_done  (op_done),
  .req_valid(req_valid),
  .req_op   (req_op),
  .mode     (mode),
  .seq_idle (seq_idle),
  .susp_w   (susp_w),
  .ev_break (ev_break),
  .ev_drop  (ev_drop)
);

// File: tb/nfd_decoder_tb.sv
module nfd_decoder_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 49;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        op_done = 1'b0;
  logic [7:0]  prot_mask = 8'h04;
  logic [18:0] rd_addr = '0;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [18:0] req_addr;
  logic [7:0]  req_data;
  logic [1:0]  mode;
  logic [7:0]  id_rdata;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nfd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_done(op_done), .prot_mask(prot_mask), .rd_addr(rd_addr),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .mode(mode), .id_rdata(id_rdata)
  );

  // {done, addr, data, exp_valid, exp_op, exp_mode}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 19'h12345, 8'hF0, 1'b1, 3'd1, 2'd0},  // R2 single F0
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R3 program
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hA0, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h10123, 8'h3C, 1'b1, 3'd2, 2'd2},
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd2},  // R8 ignored while busy
    {1'b0, 19'h00000, 8'hB0, 1'b0, 3'd0, 2'd2},  // R9 B0 during program
    {1'b1, 19'h00000, 8'h00, 1'b0, 3'd0, 2'd0},  // R8 done
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R4 chip erase
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'h80, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'h10, 1'b1, 3'd3, 2'd2},
    {1'b1, 19'h00000, 8'h00, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R5 sector erase
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'h80, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h30000, 8'h30, 1'b1, 3'd4, 2'd2},
    {1'b0, 19'h00000, 8'hB0, 1'b1, 3'd5, 2'd0},  // R9 suspend
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R9 ignored while suspended
    {1'b0, 19'h00000, 8'h30, 1'b1, 3'd6, 2'd2},  // R9 resume
    {1'b1, 19'h00000, 8'h00, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R7 break
    {1'b0, 19'h00555, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R6 enter ident
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'h90, 1'b0, 3'd0, 2'd1},
    {1'b0, 19'h00000, 8'hF0, 1'b1, 3'd1, 2'd0},  // R2 exit via F0
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R2 three-write reset
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hF0, 1'b1, 3'd1, 2'd0},
    {1'b0, 19'h70555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R3 high bits ignored
    {1'b0, 19'h502AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h01555, 8'hA0, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00010, 8'h5A, 1'b1, 3'd2, 2'd2},
    {1'b1, 19'h00000, 8'h00, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R10 protected sector 2
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hA0, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h20001, 8'h77, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'hAA, 1'b0, 3'd0, 2'd0},  // R7 break out of ident
    {1'b0, 19'h002AA, 8'h55, 1'b0, 3'd0, 2'd0},
    {1'b0, 19'h00555, 8'h90, 1'b0, 3'd0, 2'd1},
    {1'b0, 19'h00123, 8'hAA, 1'b0, 3'd0, 2'd0},
    {1'b1, 19'h00000, 8'h00, 1'b0, 3'd0, 2'd0}   // R8 done outside busy
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mode", 32'(mode), 0);
    check("R1 req_valid", 32'(req_valid), 0);
    check("R1 id_rdata", 32'(id_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][33]) done_pulse();
      else wr(VEC[i][32:14], VEC[i][13:6]);
      check($sformatf("R11 vec %0d valid", i), 32'(req_valid), 32'(VEC[i][5]));
      check($sformatf("R2-9 vec %0d op", i), 32'(req_op), 32'(VEC[i][4:2]));
      check($sformatf("R8 vec %0d mode", i), 32'(mode), 32'(VEC[i][1:0]));
    end

    // R6 identification reads
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
    rd_addr = 19'h00000; #1 check("R6 mfr", 32'(id_rdata), 32'h7F);
    rd_addr = 19'h00001; #1 check("R6 dev", 32'(id_rdata), 32'hA4);
    rd_addr = 19'h20002; #1 check("R6 prot sector 2", 32'(id_rdata), 32'h01);
    rd_addr = 19'h30002; #1 check("R6 unprot sector 3", 32'(id_rdata), 32'h00);
    rd_addr = 19'h00005; #1 check("R6 other offset", 32'(id_rdata), 32'h00);
    wr(19'h00000, 8'hF0);
    rd_addr = 19'h00000; #1 check("R6 outside ident", 32'(id_rdata), 32'h00);

    // R3 request payload, R11 single cycle
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'hA0);
    wr(19'h45678, 8'h99);
    check("R3 req_addr", 32'(req_addr), 32'h45678);
    check("R3 req_data", 32'(req_data), 32'h99);
    @(negedge clk);
    check("R11 one cycle", 32'(req_valid), 0);
    done_pulse();

    // R5 sector erase payload
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h80);
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h6ABCD, 8'h30);
    check("R5 req_addr", 32'(req_addr), 32'h6ABCD);
    check("R5 op", 32'(req_op), 4);
    done_pulse();
    check("R8 mode after done", 32'(mode), 0);

    finish_run();
  end
endmodule